// File: doc/BRIEF.md
# Four-Channel Block-Transfer DMA Controller

This block moves data between devices and memory on behalf of a host processor. It has four channels. Each channel holds a 16-bit memory start address and a 16-bit cycle-count word. Two shared registers complete the set. A mode register turns individual channels on and off. A status register collects one terminal-count flag per channel. The host programs all ten registers through a narrow 8-bit port.

When an enabled channel raises its request line, the controller asks the host for the bus by raising `hold`, then waits for `hlda`. Once the grant arrives it picks the highest-priority pending channel and runs that channel's whole programmed burst, one memory cycle per clock. In each cycle it drives the address, the device acknowledge and the read or write strobe chosen by the channel's cycle type. When the count is exhausted it records the terminal count, switches the channel off, drops `hold` and waits for the host to take the bus back.

The sequencer has four states:
- `ST_IDLE`: the bus is free.
- `ST_HOLD`: the bus has been requested and the grant is awaited.
- `ST_XFER`: the burst is running.
- `ST_DONE`: the bus is being handed back.

It has five transitions:
- `ST_IDLE`→`ST_HOLD` on an enabled request.
- `ST_HOLD`→`ST_XFER` on a grant while a request is still pending.
- `ST_HOLD`→`ST_DONE` on a grant with nothing pending.
- `ST_XFER`→`ST_DONE` on the last cycle of the burst.
- `ST_DONE`→`ST_IDLE` once `hlda` is low.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, `hold`, `dack`, `mem_rd` and `mem_wr` are all 0. Every channel register reads 0, the status reads 0, every channel is disabled and the byte pointer is at the low byte.
- R2: The register address selects a channel register or the shared register:
  - Addresses 0 to 7 select a channel register. The channel is address bits [2:1]. Address bit 0 picks the register: 0 is the start address and 1 is the count word.
  - Address 8 writes the mode register and reads the status register.
  - Reads return the current register contents.
- R3: A single byte pointer covers all channel registers. Each read or write of a channel register first uses the low byte and then the high byte, and each access toggles the pointer. Any write to the mode register returns the pointer to the low byte.
- R4: Mode bits [3:0] enable channels 0 to 3. A request on a disabled channel never raises `hold`.
- R5: `hold` rises in the cycle after an enabled request is seen. No `dack` or strobe is driven before `hlda` is high, and none is driven in the first cycle of `hold`.
- R6: Channel 0 has the highest priority and channel 3 the lowest. Only one channel is serviced per bus grant.
- R7: A count field (bits [13:0]) of N-1 gives exactly N consecutive transfer cycles. `dack` is one-hot for the serviced channel, and `mem_addr` starts at the programmed address and rises by one each cycle.
- R8: Count bits [15:14] set the cycle type:
  - 01 writes memory: `mem_wr` is high in each cycle.
  - 10 reads memory: `mem_rd` is high in each cycle.
  - 00 (verify) and 11 (illegal) drive no strobe.
  - `mem_rd` and `mem_wr` are never high together.
- R9: On the cycle whose count field is 0, several things happen together:
  - The channel's status bit (bit number = channel) is set.
  - The channel's enable bit is cleared.
  - The count field wraps to 0x3FFF and the type bits are kept.
  - The address register holds the next address.
- R10: Reading the status register clears all terminal-count flags. A flag being set in the same cycle survives the read.
- R11: After the last transfer `hold` drops. A new `hold` is not raised while `hlda` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register port select |
| cpu_rd | input | 1 | Register read strobe (one cycle per access) |
| cpu_wr | input | 1 | Register write strobe (one cycle per access) |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rdata | output | 8 | Read data byte |
| dreq | input | 4 | Per-channel service requests |
| dack | output | 4 | Per-channel acknowledge, high during transfer cycles |
| hold | output | 1 | Bus request to the host |
| hlda | input | 1 | Bus grant from the host |
| mem_addr | output | 16 | Memory address during transfer cycles, 0 otherwise |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
The bench targets several corner cases:
- **Delayed grant.** A long grant delay exposes a design that starts strobing before `hlda`.
- **Simultaneous requests.** Requests on three channels at once expose a design that picks the wrong channel or merges bursts under one grant.
- **Burst length.** A one-cycle burst and a two-cycle burst catch an off-by-one in the cycles-minus-one count.
- **Stale pointer.** A half-written register followed by a mode write would leave a stale high byte if the pointer were not cleared.
- **Slow release.** A slow bus release followed by a waiting request shows whether `hold` is reasserted too early.
- **Terminal count.** The count word and the status are read back after terminal count. This shows a design that does not wrap the field, does not auto-disable the channel (it would request again), or does not clear the flags on a status read.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    // Cycle-type codes held in the two upper bits of a count word
    localparam logic [1:0] XT_VERIFY  = 2'b00;
    localparam logic [1:0] XT_TOMEM   = 2'b01;
    localparam logic [1:0] XT_FROMMEM = 2'b10;
    localparam logic [1:0] XT_BAD     = 2'b11;

endpackage

// File: rtl/dma4_regs.sv
module dma4_regs #(
    parameter  int NCH = 4,
    parameter  int AW  = 16,
    parameter  int CW  = 14,
    localparam int RAW = $clog2(2 * NCH + 1),
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RW  = CW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_sel,
    input  logic           cpu_rd,
    input  logic           cpu_wr,
    input  logic [RAW-1:0] cpu_addr,
    input  logic [7:0]     cpu_wdata,
    output logic [7:0]     cpu_rdata,
    input  logic           step,
    input  logic [CHW-1:0] step_ch,
    output logic [AW-1:0]  base_q [NCH],
    output logic [RW-1:0]  cnt_q  [NCH],
    output logic [NCH-1:0] en_q
);

    localparam logic [RAW-1:0] SHARED_A = RAW'(2 * NCH);

    logic           ptr_q;
    logic [NCH-1:0] tc_q;
    logic [NCH-1:0] tc_hit;
    logic [NCH-1:0] en_d;
    logic           in_ch;
    logic           ch_acc;
    logic           ch_wr;
    logic           mode_wr;
    logic           stat_rd;
    logic [CHW-1:0] acc_idx;
    logic [15:0]    word;

    assign in_ch   = cpu_addr < SHARED_A;
    assign acc_idx = cpu_addr[CHW:1];
    assign ch_acc  = cpu_sel && in_ch && (cpu_rd || cpu_wr);
    assign ch_wr   = cpu_sel && in_ch && cpu_wr;
    assign mode_wr = cpu_sel && cpu_wr && (cpu_addr == SHARED_A);
    assign stat_rd = cpu_sel && cpu_rd && (cpu_addr == SHARED_A);

    // Per-channel address and count registers
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [AW-1:0] base_r;
        logic [RW-1:0] cnt_r;
        logic          hit_w;
        logic          hit_s;

        assign hit_w = ch_wr && (acc_idx == CHW'(g));
        assign hit_s = step && (step_ch == CHW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_r <= '0;
                cnt_r  <= '0;
            end else begin
                if (hit_w && !cpu_addr[0]) begin
                    if (ptr_q) base_r[AW-1:8] <= cpu_wdata[AW-9:0];
                    else       base_r[7:0]    <= cpu_wdata;
                end
                if (hit_w && cpu_addr[0]) begin
                    if (ptr_q) cnt_r[RW-1:8] <= cpu_wdata[RW-9:0];
                    else       cnt_r[7:0]    <= cpu_wdata;
                end
                // The transfer update takes precedence over a same-cycle write
                if (hit_s) begin
                    base_r         <= base_r + 1'b1;
                    cnt_r[CW-1:0]  <= cnt_r[CW-1:0] - 1'b1;
                end
            end
        end

        assign tc_hit[g] = hit_s && (cnt_r[CW-1:0] == '0);
        assign base_q[g] = base_r;
        assign cnt_q[g]  = cnt_r;
    end

    // Shared mode, status and byte pointer
    assign en_d = mode_wr ? cpu_wdata[NCH-1:0] : en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= 1'b0;
            en_q  <= '0;
            tc_q  <= '0;
        end else begin
            if (ch_acc)  ptr_q <= ~ptr_q;
            if (mode_wr) ptr_q <= 1'b0;
            en_q <= en_d & ~tc_hit;
            tc_q <= (stat_rd ? '0 : tc_q) | tc_hit;
        end
    end

    // Read data
    always_comb begin
        cpu_rdata = '0;
        word      = '0;
        if (in_ch) begin
            word      = cpu_addr[0] ? 16'(cnt_q[acc_idx]) : 16'(base_q[acc_idx]);
            cpu_rdata = ptr_q ? word[15:8] : word[7:0];
        end else if (cpu_addr == SHARED_A) begin
            cpu_rdata = 8'(tc_q);
        end
    end

endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
    parameter  int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx
);

    // Lowest index wins: scan from the top so the last hit is the smallest
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = CHW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
    import dma4_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hlda,
    input  logic           pend,
    input  logic [CHW-1:0] win_idx,
    input  logic           last,
    input  logic [1:0]     xtype,
    output logic           hold,
    output logic           step,
    output logic           xfer_on,
    output logic [CHW-1:0] act_ch,
    output logic [NCH-1:0] dack,
    output logic           mem_rd,
    output logic           mem_wr
);

    seq_state_e state_q, state_d;

    // State register and serviced-channel latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_ch  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HOLD && hlda && pend) act_ch <= win_idx;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pend) state_d = ST_HOLD;
            ST_HOLD: if (hlda) state_d = pend ? ST_XFER : ST_DONE;
            ST_XFER: if (last) state_d = ST_DONE;
            ST_DONE: if (!hlda) state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hold    = 1'b0;
        step    = 1'b0;
        xfer_on = 1'b0;
        dack    = '0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HOLD: hold = 1'b1;
            ST_XFER: begin
                hold    = 1'b1;
                step    = 1'b1;
                xfer_on = 1'b1;
                dack    = NCH'(1) << act_ch;
                mem_wr  = (xtype == XT_TOMEM);
                mem_rd  = (xtype == XT_FROMMEM);
            end
            ST_DONE: ;
        endcase
    end

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl #(
    parameter  int NCH = 4,
    parameter  int AW  = 16,
    parameter  int CW  = 14,
    localparam int RAW = $clog2(2 * NCH + 1),
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_sel,
    input  logic           cpu_rd,
    input  logic           cpu_wr,
    input  logic [RAW-1:0] cpu_addr,
    input  logic [7:0]     cpu_wdata,
    output logic [7:0]     cpu_rdata,
    input  logic [NCH-1:0] dreq,
    output logic [NCH-1:0] dack,
    output logic           hold,
    input  logic           hlda,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_wr
);

    localparam int RW = CW + 2;

    logic [AW-1:0]  base_q [NCH];
    logic [RW-1:0]  cnt_q  [NCH];
    logic [NCH-1:0] en_q;
    logic           pend;
    logic [CHW-1:0] win_idx;
    logic [CHW-1:0] act_ch;
    logic           step;
    logic           xfer_on;
    logic           last;
    logic [1:0]     xtype;

    dma4_regs #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_sel   (cpu_sel),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .step      (step),
        .step_ch   (act_ch),
        .base_q    (base_q),
        .cnt_q     (cnt_q),
        .en_q      (en_q)
    );

    dma4_arb #(.NCH(NCH)) u_arb (
        .req (dreq & en_q),
        .any (pend),
        .idx (win_idx)
    );

    assign last  = (cnt_q[act_ch][CW-1:0] == '0);
    assign xtype = cnt_q[act_ch][RW-1:CW];

    dma4_seq #(.NCH(NCH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hlda    (hlda),
        .pend    (pend),
        .win_idx (win_idx),
        .last    (last),
        .xtype   (xtype),
        .hold    (hold),
        .step    (step),
        .xfer_on (xfer_on),
        .act_ch  (act_ch),
        .dack    (dack),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr)
    );

    assign mem_addr = xfer_on ? base_q[act_ch] : '0;

endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hold,
    input logic           hlda,
    input logic [NCH-1:0] dack,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_rd,
    input logic           mem_wr
);

    // R7
    dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8
    strobe_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (|dack));

    // R5
    dack_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> (hold && hlda));

    // R5
    hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> !(|dack));

    // R6
    one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dack) && $past(|dack)) |-> (dack == $past(dack)));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dack) && $past(|dack)) |-> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .hlda     (hlda),
    .dack     (dack),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr)
);

// File: tb/sim_dma4_ctrl.sv
`timescale 1ns/1ps
module sim_dma4_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic        hold;
    logic        hlda = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;

    int n_chk = 0, n_fail = 0;
    int gnt_lat = 2, rel_lat = 1;

    always #2 clk = ~clk;

    dma4_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dreq(dreq), .dack(dack), .hold(hold), .hlda(hlda),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Behavioural reference model, stepped on each rising edge
    logic [15:0] m_base [4] = '{default: '0};
    logic [15:0] m_cnt  [4] = '{default: '0};
    logic [3:0]  m_en = '0, m_tc = '0;
    bit          m_ptr = 0;
    int          m_st = 0, m_ch = 0;

    always @(posedge clk) begin : model
        logic [15:0] nb [4];
        logic [15:0] nc [4];
        logic [3:0]  nen, ntc;
        bit          nptr, pend;
        int          nst, nch, lo, c;
        if (!rst_n) begin
            m_base = '{default: '0}; m_cnt = '{default: '0};
            m_en = '0; m_tc = '0; m_ptr = 0; m_st = 0; m_ch = 0;
        end else begin
            nb = m_base; nc = m_cnt; nen = m_en; ntc = m_tc; nptr = m_ptr;
            nst = m_st; nch = m_ch;
            pend = |(dreq & m_en);
            lo = 0;
            for (int i = 3; i >= 0; i--) if (dreq[i] && m_en[i]) lo = i;
            if (cpu_sel && (cpu_wr || cpu_rd) && cpu_addr < 8) nptr = !m_ptr;
            if (cpu_sel && cpu_wr && cpu_addr < 8) begin
                c = int'(cpu_addr[2:1]);
                if (cpu_addr[0]) begin
                    if (m_ptr) nc[c][15:8] = cpu_wdata; else nc[c][7:0] = cpu_wdata;
                end else begin
                    if (m_ptr) nb[c][15:8] = cpu_wdata; else nb[c][7:0] = cpu_wdata;
                end
            end
            if (cpu_sel && cpu_wr && cpu_addr == 8) begin nen = cpu_wdata[3:0]; nptr = 0; end
            if (cpu_sel && cpu_rd && cpu_addr == 8) ntc = '0;
            case (m_st)
                0: if (pend) nst = 1;
                1: if (hlda) begin
                       if (pend) begin nst = 2; nch = lo; end else nst = 3;
                   end
                2: begin
                       c = m_ch;
                       nb[c] = m_base[c] + 16'd1;
                       nc[c][13:0] = m_cnt[c][13:0] - 14'd1;
                       if (m_cnt[c][13:0] == 0) begin ntc[c] = 1'b1; nen[c] = 1'b0; nst = 3; end
                   end
                default: if (!hlda) nst = 0;
            endcase
            m_base = nb; m_cnt = nc; m_en = nen; m_tc = ntc; m_ptr = nptr;
            m_st = nst; m_ch = nch;
        end
    end

    // Per-cycle comparison, away from the rising edge
    always @(negedge clk) begin : compare
        logic [15:0] w;
        logic [7:0]  er;
        bit          x;
        #1;
        x = (m_st == 2);
        chk("R5 hold", hold, (m_st == 1 || m_st == 2));
        chk("R6 dack", dack, x ? (4'b1 << m_ch) : 4'b0);
        chk("R7 mem_addr", mem_addr, x ? m_base[m_ch] : 16'h0);
        chk("R8 mem_rd", mem_rd, x && m_cnt[m_ch][15:14] == 2'b10);
        chk("R8 mem_wr", mem_wr, x && m_cnt[m_ch][15:14] == 2'b01);
        if (cpu_sel && cpu_rd) begin
            er = '0;
            if (cpu_addr < 8) begin
                w  = cpu_addr[0] ? m_cnt[cpu_addr[2:1]] : m_base[cpu_addr[2:1]];
                er = m_ptr ? w[15:8] : w[7:0];
            end else if (cpu_addr == 8) er = {4'b0, m_tc};
            chk("R2 rdata", cpu_rdata, er);
        end
    end

    // Host bus-grant model
    initial begin : host
        int gc = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin hlda = 1'b0; gc = 0; end
            else if (hold && !hlda) begin
                gc++; if (gc >= gnt_lat) begin hlda = 1'b1; gc = 0; end
            end else if (!hold && hlda) begin
                gc++; if (gc >= rel_lat) begin hlda = 1'b0; gc = 0; end
            end else gc = 0;
        end
    end

    // Observation of serviced channels and strobes
    int order[$];
    int xcnt [4], rcnt [4], wcnt [4];
    int bad_rise = 0;
    logic prev_dack_any = 1'b0, prev_hold = 1'b0;

    always @(negedge clk) begin : observe
        #1;
        if (rst_n) begin
            for (int i = 0; i < 4; i++) begin
                if (dack[i]) begin
                    xcnt[i]++;
                    if (mem_rd) rcnt[i]++;
                    if (mem_wr) wcnt[i]++;
                    if (!prev_dack_any) order.push_back(i);
                end
            end
            if (hold && !prev_hold && hlda) bad_rise++;
        end
        prev_dack_any = |dack;
        prev_hold = hold;
    end

    task automatic clear_obs;
        order.delete();
        for (int i = 0; i < 4; i++) begin xcnt[i] = 0; rcnt[i] = 0; wcnt[i] = 0; end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_sel = 0; cpu_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); cpu_sel = 1; cpu_rd = 1; cpu_addr = a;
        #1 v = cpu_rdata;
        @(negedge clk); cpu_sel = 0; cpu_rd = 0;
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] d);
        wr(a, d[7:0]); wr(a, d[15:8]);
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo); rd(a, hi); v = {hi, lo};
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        summary();
    end

    initial begin : main
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 hold", hold, 0); chk("R1 dack", dack, 0);
        chk("R1 strobes", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        rd(4'd8, b); chk("R1 status", b, 8'h00);
        rd16(4'd0, v); chk("R1 ch0 addr", v, 16'h0000);

        // R2 / R3 register access and byte pointer
        wr16(4'd0, 16'h1234); wr16(4'd1, 16'h4003);
        rd16(4'd0, v); chk("R2 ch0 addr", v, 16'h1234);
        rd16(4'd1, v); chk("R3 ch0 count", v, 16'h4003);
        wr(4'd2, 8'hAA); wr(4'd8, 8'h00); wr16(4'd2, 16'h6655);
        rd16(4'd2, v); chk("R3 pointer reset by mode write", v, 16'h6655);

        // R4 disabled channel ignored
        dreq = 4'b0001;
        repeat (10) @(negedge clk);
        chk("R4 no hold when disabled", hold, 0);

        // R5 grant wait, then a 4-cycle write burst on ch0
        gnt_lat = 12;
        clear_obs();
        wr(4'd8, 8'h01);
        repeat (6) @(negedge clk);
        #1 chk("R5 hold waiting", hold, 1); chk("R5 no dack before grant", dack, 0);
        repeat (40) @(negedge clk);
        chk("R7 ch0 cycles", xcnt[0], 4); chk("R8 ch0 writes", wcnt[0], 4);
        rd(4'd8, b); chk("R9 status ch0", b, 8'h01);
        rd(4'd8, b); chk("R10 status cleared", b, 8'h00);
        rd16(4'd1, v); chk("R9 count wrapped", v, 16'h7FFF);
        rd16(4'd0, v); chk("R7 addr advanced", v, 16'h1238);
        repeat (10) @(negedge clk);
        chk("R9 auto-disable", hold, 0);

        // R6 / R7 / R8 priority across three channels
        gnt_lat = 2;
        wr16(4'd2, 16'h2000); wr16(4'd3, 16'h8001);
        wr16(4'd4, 16'h3000); wr16(4'd5, 16'h0000);
        wr16(4'd6, 16'h4000); wr16(4'd7, 16'hC000);
        clear_obs();
        dreq = 4'b1110;
        wr(4'd8, 8'h0E);
        repeat (60) @(negedge clk);
        chk("R6 order size", order.size(), 3);
        if (order.size() == 3) begin
            chk("R6 first ch1", order[0], 1); chk("R6 second ch2", order[1], 2);
            chk("R6 third ch3", order[2], 3);
        end
        chk("R7 ch1 cycles", xcnt[1], 2); chk("R7 ch2 cycles", xcnt[2], 1);
        chk("R7 ch3 cycles", xcnt[3], 1);
        chk("R8 ch1 reads", rcnt[1], 2); chk("R8 ch1 writes", wcnt[1], 0);
        chk("R8 verify/illegal silent", rcnt[2] + wcnt[2] + rcnt[3] + wcnt[3], 0);
        rd(4'd8, b); chk("R9 status ch1-3", b, 8'h0E);

        // R11 slow release with a waiting request
        rel_lat = 6;
        wr16(4'd0, 16'h0100); wr16(4'd1, 16'h4000);
        wr16(4'd2, 16'h0200); wr16(4'd3, 16'h4000);
        clear_obs();
        dreq = 4'b0011;
        wr(4'd8, 8'h03);
        repeat (60) @(negedge clk);
        chk("R11 no hold while hlda high", bad_rise, 0);
        chk("R6 one channel per grant", order.size(), 2);
        if (order.size() == 2) begin
            chk("R6 ch0 before ch1", order[0], 0); chk("R6 ch1 second", order[1], 1);
        end
        chk("R11 released", hold, 0);
        summary();
    end

endmodule